// File: doc/BRIEF.md
# Dual-Source Serial Baud Tick Generator

This block produces the 16x oversampling tick enable for a 16550-style serial port. Software loads a 16-bit divisor latch one byte at a time. With the divisor-access bit of the line control register set, a write to offset 0 goes to the low byte and a write to offset 1 goes to the high byte. With that bit clear, the same offsets belong to the data and interrupt-enable registers, and the latch ignores them. The latch value is always available for readback.

Bit 15 of the latch does not count. It chooses between two internal reference clocks: the faster reference (48 MHz in the target system) when it is 1, and the slower reference (1.8432 MHz) when it is 0. Bits [14:0] give the divide count N. A configuration input can route an external clock instead, and this overrides bit 15. The resulting baud rate is source / (16 * N). All clock sources arrive as one-cycle enable strobes in the single system clock domain. A down-counter in front of the output counts strobes of the selected source and emits one tick for every N strobes.

A count of zero is invalid and gives no ticks. When the block is not activated, the generator is gated off. Any write to the latch restarts the count.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor readback is 0x0000 and the tick output is low.
- R2: A write with the access bit set stores its byte in the low half of the latch at offset 0, or in the high half at offset 1. The readback shows the new value from the cycle after the write.
- R3: A write with the access bit clear, or to any offset other than 0 and 1, leaves the latch unchanged.
- R4: With the external select low, latch bit 15 = 1 counts strobes of the fast reference, and bit 15 = 0 counts strobes of the slow reference. Strobes of the source that is not selected have no effect.
- R5: With the external select high, only strobes of the external clock input are counted, whatever latch bit 15 holds.
- R6: With a nonzero count N in bits [14:0], the tick goes high for one cycle, in the cycle after the edge that samples every N-th selected strobe counted since the last restart. N = 1 gives a tick for every strobe.
- R7: A count of zero in bits [14:0] produces no tick.
- R8: Every latch write restarts the count, so the next tick follows N selected strobes after the write. A strobe that arrives in the same cycle as the write is not counted and produces no tick.
- R9: While the activate input is low, no tick is produced and the count restarts. Once the input returns high, the next tick comes after N strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active_en | input | 1 | Block activated; low gates the generator off |
| ext_clk_sel | input | 1 | Count the external clock strobe instead of an internal reference |
| dl_access | input | 1 | Divisor-access bit from the line control register |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 3 | Register offset of the write |
| reg_wdata | input | 8 | Register write data |
| slow_ref_stb | input | 1 | Enable strobe of the slow internal reference |
| fast_ref_stb | input | 1 | Enable strobe of the fast internal reference |
| ext_clk_stb | input | 1 | Enable strobe of the external clock input |
| tick16 | output | 1 | One-cycle 16x oversampling tick |
| div_rd | output | 16 | Divisor latch readback |

## Verification
Two events can meet in one cycle: a latch write and a strobe of the selected source. This includes a strobe that would have completed a period. The bench provokes it by counting N-1 strobes and then issuing a byte write to the latch together with the N-th strobe. It expects no tick in the following cycle and a tick only after N further strobes. The same collision is also produced while the external source is selected, so that the restart is judged independently of the select path.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 3;
  localparam int unsigned CNT_W  = DIV_W - 1;
  localparam int unsigned LANES  = DIV_W / BYTE_W;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  function automatic cnt_t div_count(input div_t d);
    return d[CNT_W-1:0];
  endfunction

  function automatic logic div_fast(input div_t d);
    return d[DIV_W-1];
  endfunction

  function automatic cnt_t reload_of(input div_t d);
    cnt_t c;
    c = div_count(d);
    return (c == '0) ? '0 : cnt_t'(c - 1'b1);
  endfunction

  function automatic src_e pick_src(input logic ext, input div_t d);
    if (ext) return SRC_EXT;
    return div_fast(d) ? SRC_FAST : SRC_SLOW;
  endfunction
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch
  import baud_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic             dl_access,
  output div_t             div_q,
  output div_t             div_d,
  output logic             wr_hit
);
  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_hit[g] = reg_we && dl_access && (reg_off == OFF_W'(g));
      div_d[g*BYTE_W +: BYTE_W] = lane_hit[g] ? reg_wdata : div_q[g*BYTE_W +: BYTE_W];
    end
  end

  assign wr_hit = |lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(div_q)); // R3
endmodule

// File: rtl/baud_src_mux.sv
module baud_src_mux
  import baud_gen_pkg::*;
(
  input  logic ext_clk_sel,
  input  div_t div_q,
  input  logic slow_ref_stb,
  input  logic fast_ref_stb,
  input  logic ext_clk_stb,
  output logic src_stb
);
  src_e sel;

  always_comb begin
    sel = pick_src(ext_clk_sel, div_q);
    unique case (sel)
      SRC_EXT:  src_stb = ext_clk_stb;
      SRC_FAST: src_stb = fast_ref_stb;
      default:  src_stb = slow_ref_stb;
    endcase
  end
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter
  import baud_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_en,
  input  logic restart,
  input  div_t div_q,
  input  div_t div_d,
  input  logic src_stb,
  output logic tick,
  output cnt_t cnt
);
  cnt_t count_now;
  logic period_end;

  assign count_now  = div_count(div_q);
  assign period_end = src_stb && (count_now != '0) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (restart || !active_en) begin
        cnt <= reload_of(div_d);
      end else if (src_stb && count_now != '0) begin
        if (period_end) begin
          tick <= 1'b1;
          cnt  <= reload_of(div_q);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (count_now != '0) |-> (cnt < count_now)); // R6
  AST_TICK_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(src_stb)); // R6
  AST_NO_TICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_now == '0) |=> !tick); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R8
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active_en |=> !tick); // R9
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_en,
  input  logic              ext_clk_sel,
  input  logic              dl_access,
  input  logic              reg_we,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              slow_ref_stb,
  input  logic              fast_ref_stb,
  input  logic              ext_clk_stb,
  output logic              tick16,
  output logic [DIV_W-1:0]  div_rd
);
  div_t div_q;
  div_t div_d;
  logic wr_hit;
  logic src_stb;
  cnt_t cnt;

  baud_div_latch u_latch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .dl_access(dl_access),
    .div_q(div_q), .div_d(div_d), .wr_hit(wr_hit)
  );

  baud_src_mux u_mux (
    .ext_clk_sel(ext_clk_sel), .div_q(div_q), .slow_ref_stb(slow_ref_stb),
    .fast_ref_stb(fast_ref_stb), .ext_clk_stb(ext_clk_stb), .src_stb(src_stb)
  );

  baud_down_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .active_en(active_en), .restart(wr_hit),
    .div_q(div_q), .div_d(div_d), .src_stb(src_stb), .tick(tick16), .cnt(cnt)
  );

  assign div_rd = div_q;

  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cnt == reload_of(div_q))); // R8
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active_en = 1'b0, ext_clk_sel = 1'b0, dl_access = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_off = '0;
  logic [7:0] reg_wdata = '0;
  logic slow_ref_stb = 1'b0, fast_ref_stb = 1'b0, ext_clk_stb = 1'b0;
  logic tick16;
  logic [15:0] div_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string req_q[$];

  logic [15:0] m_div = '0;
  int m_seen = 0;
  bit m_act = 1'b0;
  bit m_ext = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .active_en(active_en), .ext_clk_sel(ext_clk_sel),
    .dl_access(dl_access), .reg_we(reg_we), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .slow_ref_stb(slow_ref_stb), .fast_ref_stb(fast_ref_stb), .ext_clk_stb(ext_clk_stb),
    .tick16(tick16), .div_rd(div_rd)
  );

  // monitor: compares the tick against the expected item for each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (tick16 !== e) begin
          errors++;
          $display("FAIL %s: tick16 actual=%0b expected=%0b at %0t", r, tick16, e, $time);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected tick
  task automatic drv(bit we, logic [2:0] off, logic [7:0] d, bit acc,
                     bit s, bit f, bit e, string req);
    bit exp;
    bit sel;
    int n;
    @(negedge clk);
    reg_we = we; reg_off = off; reg_wdata = d; dl_access = acc;
    slow_ref_stb = s; fast_ref_stb = f; ext_clk_stb = e;
    active_en = m_act; ext_clk_sel = m_ext;
    exp = 1'b0;
    if (we && acc && off < 3'd2) begin
      if (off == 3'd0) m_div[7:0] = d;
      else             m_div[15:8] = d;
      m_seen = 0;
    end else if (!m_act) begin
      m_seen = 0;
    end else begin
      sel = m_ext ? e : (m_div[15] ? f : s);
      n = int'(m_div[14:0]);
      if (sel && n != 0) begin
        m_seen++;
        if (m_seen == n) begin
          exp = 1'b1;
          m_seen = 0;
        end
      end
    end
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(posedge clk);
    #2;
    reg_we = 1'b0; slow_ref_stb = 1'b0; fast_ref_stb = 1'b0; ext_clk_stb = 1'b0;
  endtask

  task automatic chk_div(logic [15:0] exp, string req);
    checks++;
    if (div_rd !== exp) begin
      errors++;
      $display("FAIL %s: div_rd actual=%04h expected=%04h", req, div_rd, exp);
    end
  endtask

  task automatic wr(logic [2:0] off, logic [7:0] d, bit acc, string req);
    drv(1'b1, off, d, acc, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (tick16 !== 1'b0 || div_rd !== 16'h0000) begin
      errors++;
      $display("FAIL R1: reset actual tick=%0b div=%04h expected tick=0 div=0000", tick16, div_rd);
    end
    rst_n = 1'b1;
    m_act = 1'b1;
    drv(0, 0, 0, 0, 1, 1, 1, "R7");

    // R3: writes that must not reach the latch
    wr(3'd0, 8'h55, 1'b0, "R3");
    chk_div(16'h0000, "R3 access clear");
    wr(3'd2, 8'h66, 1'b1, "R3");
    chk_div(16'h0000, "R3 other offset");

    // R2: byte lanes; count 3 on slow reference
    wr(3'd0, 8'h03, 1'b1, "R2");
    chk_div(16'h0003, "R2 low byte");
    wr(3'd1, 8'h00, 1'b1, "R2");
    chk_div(16'h0003, "R2 high byte");
    for (int i = 0; i < 12; i++) drv(0, 0, 0, 0, i[0], ~i[0], 1, "R4 slow R6");

    // R4: bit 15 picks fast reference
    wr(3'd1, 8'h80, 1'b1, "R2");
    chk_div(16'h8003, "R2 high byte bit15");
    for (int i = 0; i < 12; i++) drv(0, 0, 0, 0, ~i[0], i[0], 0, "R4 fast R6");

    // R5: external override, count 2
    wr(3'd0, 8'h02, 1'b1, "R5");
    m_ext = 1'b1;
    for (int i = 0; i < 10; i++) drv(0, 0, 0, 0, 1, 1, (i % 3) != 2, "R5 ext");

    // R8: collision of write and completing strobe on external source
    drv(0, 0, 0, 0, 0, 0, 1, "R8");
    wr(3'd0, 8'h02, 1'b1, "R8");
    drv(0, 0, 0, 0, 0, 0, 1, "R8");
    drv(1, 3'd0, 8'h02, 1, 0, 0, 1, "R8 collision");
    for (int i = 0; i < 4; i++) drv(0, 0, 0, 0, 0, 0, 1, "R8 after");
    m_ext = 1'b0;

    // R8: collision on slow source, count 4
    wr(3'd1, 8'h00, 1'b1, "R8");
    wr(3'd0, 8'h04, 1'b1, "R8");
    for (int i = 0; i < 3; i++) drv(0, 0, 0, 0, 1, 0, 0, "R8 prefill");
    drv(1, 3'd0, 8'h04, 1, 1, 0, 0, "R8 collision slow");
    for (int i = 0; i < 9; i++) drv(0, 0, 0, 0, 1, 0, 0, "R8 restart slow");

    // R6: count 1 ticks on every strobe
    wr(3'd0, 8'h01, 1'b1, "R6");
    for (int i = 0; i < 6; i++) drv(0, 0, 0, 0, 1, 0, 0, "R6 n=1");

    // R7: zero count
    wr(3'd0, 8'h00, 1'b1, "R7");
    chk_div(16'h0000, "R7 zero");
    for (int i = 0; i < 6; i++) drv(0, 0, 0, 0, 1, 1, 1, "R7 zero count");
    wr(3'd1, 8'h80, 1'b1, "R7");
    for (int i = 0; i < 4; i++) drv(0, 0, 0, 0, 1, 1, 1, "R7 zero fast");

    // R9: gated off, then reactivated with count 3 on slow
    wr(3'd1, 8'h00, 1'b1, "R9");
    wr(3'd0, 8'h03, 1'b1, "R9");
    drv(0, 0, 0, 0, 1, 0, 0, "R9");
    drv(0, 0, 0, 0, 1, 0, 0, "R9");
    m_act = 1'b0;
    for (int i = 0; i < 5; i++) drv(0, 0, 0, 0, 1, 0, 0, "R9 inactive");
    m_act = 1'b1;
    for (int i = 0; i < 7; i++) drv(0, 0, 0, 0, 1, 0, 0, "R9 reactivated");

    drv(0, 0, 0, 0, 0, 0, 0, "R6");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule